// File: doc/BRIEF.md
# SD Command Channel Engine

This block runs one command exchange on the CMD line of an SD or MMC card. Software-side logic presents a 32-bit argument and a 16-bit command word with a one-cycle issue pulse. The engine builds a 48-bit command frame, appends a CRC7 and shifts the frame out on the falling edges of the card clock it generates. It then releases the line, waits for the card's start bit and shifts in either a 48-bit or a 136-bit response.

On completion it fills four 32-bit response registers and raises a completion flag. If the response is bad or never arrives, it raises one of four error flags instead. A busy output covers the whole exchange, and the engine ignores new issue pulses while busy is high.

The command word carries the command index in bits [5:0] and an explicit response-type code in bits [10:8]. The engine does not guess the response shape from the index, except when the code asks it to. For the busy-signalling response type, the exchange stays open until the card's DAT0 line returns high.

Top module: `sdc_cmd_host`

## Requirements
- R1: On issue, the frame sent is, MSB first: start bit 0, transmission bit 1, cmdWord[5:0], the 32-bit argument, CRC7 (x^7+x^3+1) over those first 40 bits, and end bit 1. cmdOut and cmdOe change only at falling edges of sdClk, and cmdOe is high for exactly the 48 frame bits.
- R2: busy rises on an accepted issue and falls when the exchange ends with completion or timeout. An issue pulse while busy is high is ignored: no second frame is sent and the latched command stays in force.
- R3: cmdWord[10:8] selects the response type: 3 = none, 4 = short with checks, 5 = short with DAT0 busy, 6 = 136-bit long, 7 = short without CRC or index check. Codes 1 and 2 act as 4. Code 0 infers the type from the index: 0 gives none; 2, 9 and 10 give long; 1 gives code 7; 41 gives code 7 when cmdWord[6] is set and code 4 otherwise; any other index gives code 4.
- R4: With response type none, respDone rises at the sdClk falling edge that releases the line after the end bit, and no timeout is raised.
- R5: A short response puts bits [39:8] of the received frame in resp0 and clears resp1 to resp3.
- R6: A long response is stored without its low 8 bits: resp0 = bits [39:8], resp1 = [71:40], resp2 = [103:72], and resp3 = {8'h00, bits [127:104]}.
- R7: If cmdIn is not sampled low at any of the 64 sdClk rising edges that follow the line release, errTimeout is set, busy falls and respDone stays low. A start bit at the 64th edge is still accepted.
- R8: For types 4 and 5, errCrc is set when the received CRC7 in bits [7:1] does not match the CRC7 of bits [47:8].
- R9: errEnd is set when the last received bit is 0, for every response type.
- R10: For types 4 and 5, errIndex is set when the response index in bits [45:40] differs from the issued command index.
- R11: Types 6 and 7 never raise errCrc or errIndex.
- R12: For type 5, busy stays high and respDone stays low after the response until dat0In is high. Then both change together.
- R13: After reset all flags are low, busy is low and cmdOut is 1. A new accepted issue or a clearStatus pulse clears respDone and all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | One-cycle pulse that starts a command |
| cmdWord | input | 16 | Index [5:0], app flag [6], response code [10:8], data flags [14:11] |
| cmdArg | input | 32 | Command argument |
| clearStatus | input | 1 | Clears completion and error flags |
| cmdIn | input | 1 | CMD line as seen from the card |
| dat0In | input | 1 | DAT0 line, used for busy signalling |
| sdClk | output | 1 | Card clock, system clock divided by 2*HALF_DIV |
| cmdOut | output | 1 | CMD line drive value |
| cmdOe | output | 1 | CMD line drive enable |
| busy | output | 1 | Command exchange in progress |
| respDone | output | 1 | Response complete |
| errTimeout | output | 1 | No start bit within the window |
| errCrc | output | 1 | Response CRC mismatch |
| errEnd | output | 1 | Response end bit missing |
| errIndex | output | 1 | Response index mismatch |
| resp0 | output | 32 | Response bits [39:8] |
| resp1 | output | 32 | Long response bits [71:40] |
| resp2 | output | 32 | Long response bits [103:72] |
| resp3 | output | 32 | Long response bits [127:104], zero-extended |

## Verification
The bench places the card's start bit at the 64th and at the 65th edge after release. A counter that is off by one either times out a legal reply or accepts a late one. It sends long and OCR-style replies whose CRC and index fields are junk or all ones. A design that checks those fields for every type would then flag false errors, and a wrong slice would show up in the response registers. It also issues the index-41 command under code 0 with the app bit set, which only passes if inference applies. A busy response is held by DAT0 low to catch early completion, and a second issue pulse during an exchange shows whether a busy engine restarts.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int HEAD_BITS  = 40;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SHORT,
    RK_BUSY,
    RK_LONG,
    RK_OCR
  } rspKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_DRAIN
  } seqState_t;

  // strobes from control to datapath, already qualified by clock ticks
  typedef struct packed {
    logic load;
    logic txStep;
    logic txRelease;
    logic rxClear;
    logic rxShift;
    logic capture;
  } dpCtl_t;

  function automatic logic [6:0] crc7Of(input logic [HEAD_BITS-1:0] bits);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = HEAD_BITS - 1; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c  = {c[5:3], c[2] ^ fb, c[1:0], fb};
    end
    return c;
  endfunction

  function automatic rspKind_t decodeKind(input logic [15:0] w);
    rspKind_t k;
    case (w[10:8])
      3'd3: k = RK_NONE;
      3'd4: k = RK_SHORT;
      3'd5: k = RK_BUSY;
      3'd6: k = RK_LONG;
      3'd7: k = RK_OCR;
      3'd0: begin
        case (w[5:0])
          6'd0:               k = RK_NONE;
          6'd2, 6'd9, 6'd10:  k = RK_LONG;
          6'd1:               k = RK_OCR;
          6'd41:              k = w[6] ? RK_OCR : RK_SHORT;
          default:            k = RK_SHORT;
        endcase
      end
      default: k = RK_SHORT;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [5:0]  cmdIdx,
  input  logic [31:0] cmdArg,
  input  logic        cmdIn,
  input  logic        isLong,
  output logic        sdClk,
  output logic        riseTick,
  output logic        fallTick,
  output logic        cmdOut,
  output logic        cmdOe,
  output logic        crcOk,
  output logic        endOk,
  output logic        idxOk,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3
);

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0]           divCnt;
  logic                    wrap;
  logic [FRAME_BITS-1:0]   txReg;
  logic [LONG_BITS-1:0]    rxReg;
  logic [5:0]              idxR;
  logic [HEAD_BITS-1:0]    head;

  // card clock generator
  assign wrap     = (divCnt == DIV_LAST);
  assign riseTick = wrap && !sdClk;
  assign fallTick = wrap && sdClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      sdClk  <= 1'b0;
    end else if (wrap) begin
      divCnt <= '0;
      sdClk  <= ~sdClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // transmit shifter
  assign head = {2'b01, cmdIdx, cmdArg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg  <= '1;
      idxR   <= '0;
      cmdOut <= 1'b1;
      cmdOe  <= 1'b0;
    end else begin
      if (ctl.load) begin
        txReg <= {head, crc7Of(head), 1'b1};
        idxR  <= cmdIdx;
      end else if (ctl.txStep) begin
        txReg <= {txReg[FRAME_BITS-2:0], 1'b1};
      end
      if (ctl.txStep) begin
        cmdOut <= txReg[FRAME_BITS-1];
        cmdOe  <= 1'b1;
      end else if (ctl.txRelease) begin
        cmdOut <= 1'b1;
        cmdOe  <= 1'b0;
      end
    end
  end

  // receive shifter and response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0;
      resp0 <= '0;
      resp1 <= '0;
      resp2 <= '0;
      resp3 <= '0;
    end else begin
      if (ctl.rxClear) rxReg <= '0;
      else if (ctl.rxShift) rxReg <= {rxReg[LONG_BITS-2:0], cmdIn};
      if (ctl.capture) begin
        resp0 <= rxReg[39:8];
        resp1 <= isLong ? rxReg[71:40] : '0;
        resp2 <= isLong ? rxReg[103:72] : '0;
        resp3 <= isLong ? {8'h00, rxReg[127:104]} : '0;
      end
    end
  end

  assign crcOk = (crc7Of(rxReg[47:8]) == rxReg[7:1]);
  assign endOk = rxReg[0];
  assign idxOk = (rxReg[45:40] == idxR);

  // R1
  tx_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fallTick |=> ($stable(cmdOut) && $stable(cmdOe)));

endmodule

// File: rtl/sdc_control.sv
module sdc_control
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [15:0] cmdWord,
  input  logic        clearStatus,
  input  logic        riseTick,
  input  logic        fallTick,
  input  logic        cmdIn,
  input  logic        dat0In,
  input  logic        crcOk,
  input  logic        endOk,
  input  logic        idxOk,
  output dpCtl_t      ctl,
  output logic        isLong,
  output logic        busy,
  output logic        respDone,
  output logic        errTimeout,
  output logic        errCrc,
  output logic        errEnd,
  output logic        errIndex
);

  localparam int WW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [WW-1:0] WAIT_LAST = WW'(TIMEOUT_CYC - 1);
  localparam logic [7:0] TX_LEN    = 8'(FRAME_BITS);
  localparam logic [7:0] SHORT_LEN = 8'(FRAME_BITS);
  localparam logic [7:0] LONG_LEN  = 8'(LONG_BITS);

  seqState_t   state;
  rspKind_t    kindR;
  logic [7:0]  bitCnt;
  logic [WW-1:0] waitCnt;
  logic [7:0]  rxLen;
  logic        checkFields;

  assign isLong      = (kindR == RK_LONG);
  assign rxLen       = isLong ? LONG_LEN : SHORT_LEN;
  assign checkFields = (kindR == RK_SHORT) || (kindR == RK_BUSY);

  always_comb begin
    ctl           = '0;
    ctl.load      = (state == ST_IDLE) && issueValid;
    ctl.rxClear   = ctl.load;
    ctl.txStep    = (state == ST_SEND) && fallTick && (bitCnt < TX_LEN);
    ctl.txRelease = (state == ST_SEND) && fallTick && (bitCnt == TX_LEN);
    ctl.rxShift   = riseTick && (((state == ST_WAIT) && !cmdIn) ||
                                 ((state == ST_RECV) && (bitCnt < rxLen)));
    ctl.capture   = (state == ST_RECV) && (bitCnt == rxLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kindR      <= RK_NONE;
      bitCnt     <= '0;
      waitCnt    <= '0;
      busy       <= 1'b0;
      respDone   <= 1'b0;
      errTimeout <= 1'b0;
      errCrc     <= 1'b0;
      errEnd     <= 1'b0;
      errIndex   <= 1'b0;
    end else begin
      if (clearStatus) begin
        respDone   <= 1'b0;
        errTimeout <= 1'b0;
        errCrc     <= 1'b0;
        errEnd     <= 1'b0;
        errIndex   <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (issueValid) begin
            kindR      <= decodeKind(cmdWord);
            busy       <= 1'b1;
            bitCnt     <= '0;
            respDone   <= 1'b0;
            errTimeout <= 1'b0;
            errCrc     <= 1'b0;
            errEnd     <= 1'b0;
            errIndex   <= 1'b0;
            state      <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (ctl.txStep) bitCnt <= bitCnt + 1'b1;
          if (ctl.txRelease) begin
            if (kindR == RK_NONE) begin
              respDone <= 1'b1;
              busy     <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              waitCnt <= '0;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (riseTick) begin
            if (!cmdIn) begin
              bitCnt <= 8'd1;
              state  <= ST_RECV;
            end else if (waitCnt == WAIT_LAST) begin
              errTimeout <= 1'b1;
              busy       <= 1'b0;
              state      <= ST_IDLE;
            end else begin
              waitCnt <= waitCnt + 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (ctl.rxShift) bitCnt <= bitCnt + 1'b1;
          if (ctl.capture) begin
            errEnd   <= !endOk;
            errCrc   <= checkFields && !crcOk;
            errIndex <= checkFields && !idxOk;
            if (kindR == RK_BUSY) begin
              state <= ST_DRAIN;
            end else begin
              respDone <= 1'b1;
              busy     <= 1'b0;
              state    <= ST_IDLE;
            end
          end
        end
        ST_DRAIN: begin
          if (dat0In) begin
            respDone <= 1'b1;
            busy     <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_or_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (respDone || errTimeout));

  // R7
  timeout_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(respDone && errTimeout));

  // R12
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DRAIN) && !dat0In) |=> (busy && !respDone));

  // R11
  skip_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCrc || errIndex) |-> checkFields);

  // R4
  none_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.txRelease && (kindR == RK_NONE)) |=> (respDone && !busy && !errTimeout));

endmodule

// File: rtl/sdc_cmd_host.sv
module sdc_cmd_host
  import sdc_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [15:0] cmdWord,
  input  logic [31:0] cmdArg,
  input  logic        clearStatus,
  input  logic        cmdIn,
  input  logic        dat0In,
  output logic        sdClk,
  output logic        cmdOut,
  output logic        cmdOe,
  output logic        busy,
  output logic        respDone,
  output logic        errTimeout,
  output logic        errCrc,
  output logic        errEnd,
  output logic        errIndex,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3
);

  dpCtl_t ctl;
  logic   riseTick, fallTick, isLong, crcOk, endOk, idxOk;

  sdc_control #(.TIMEOUT_CYC(TIMEOUT_CYC)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .cmdWord    (cmdWord),
    .clearStatus(clearStatus),
    .riseTick   (riseTick),
    .fallTick   (fallTick),
    .cmdIn      (cmdIn),
    .dat0In     (dat0In),
    .crcOk      (crcOk),
    .endOk      (endOk),
    .idxOk      (idxOk),
    .ctl        (ctl),
    .isLong     (isLong),
    .busy       (busy),
    .respDone   (respDone),
    .errTimeout (errTimeout),
    .errCrc     (errCrc),
    .errEnd     (errEnd),
    .errIndex   (errIndex)
  );

  sdc_datapath #(.HALF_DIV(HALF_DIV)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cmdIdx  (cmdWord[5:0]),
    .cmdArg  (cmdArg),
    .cmdIn   (cmdIn),
    .isLong  (isLong),
    .sdClk   (sdClk),
    .riseTick(riseTick),
    .fallTick(fallTick),
    .cmdOut  (cmdOut),
    .cmdOe   (cmdOe),
    .crcOk   (crcOk),
    .endOk   (endOk),
    .idxOk   (idxOk),
    .resp0   (resp0),
    .resp1   (resp1),
    .resp2   (resp2),
    .resp3   (resp3)
  );

endmodule

// File: tb/sdc_cmd_host_test.sv
module sdc_cmd_host_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [31:0] cmdArg = '0;
  logic clearStatus = 1'b0;
  logic cmdIn = 1'b1;
  logic dat0In = 1'b1;
  logic sdClk, cmdOut, cmdOe, busy, respDone, errTimeout, errCrc, errEnd, errIndex;
  logic [31:0] resp0, resp1, resp2, resp3;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic done, tmo, crc, endE, idx, chkResp;
    logic [31:0] r0, r1, r2, r3;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;

  sdc_cmd_host uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .cmdWord(cmdWord),
    .cmdArg(cmdArg), .clearStatus(clearStatus), .cmdIn(cmdIn), .dat0In(dat0In),
    .sdClk(sdClk), .cmdOut(cmdOut), .cmdOe(cmdOe), .busy(busy),
    .respDone(respDone), .errTimeout(errTimeout), .errCrc(errCrc),
    .errEnd(errEnd), .errIndex(errIndex),
    .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] benchCrc(input logic [39:0] d);
    logic [6:0] r = 7'h00;
    for (int i = 39; i >= 0; i--) begin
      logic inb;
      inb = d[i] ^ r[6];
      r = r << 1;
      if (inb) r = r ^ 7'h09;
    end
    return r;
  endfunction

  function automatic logic [135:0] mkShort(input logic [5:0] idx, input logic [31:0] pay,
                                           input logic flip, input logic endBit);
    logic [39:0] h;
    logic [6:0]  c;
    h = {2'b00, idx, pay};
    c = benchCrc(h);
    if (flip) h[12] = ~h[12];
    return {88'b0, h, c, endBit};
  endfunction

  function automatic expItem_t mkExp(input string req, input logic done, input logic tmo,
                                     input logic crc, input logic endE, input logic idx,
                                     input logic chkResp, input logic [135:0] b,
                                     input logic isLong);
    expItem_t e;
    e.req = req; e.done = done; e.tmo = tmo; e.crc = crc; e.endE = endE; e.idx = idx;
    e.chkResp = chkResp;
    e.r0 = b[39:8];
    e.r1 = isLong ? b[71:40] : 32'h0;
    e.r2 = isLong ? b[103:72] : 32'h0;
    e.r3 = isLong ? {8'h00, b[127:104]} : 32'h0;
    return e;
  endfunction

  task automatic cardReply(input logic [135:0] bits, input int len, input int gap);
    repeat (gap) @(negedge sdClk);
    cmdIn = bits[len-1];
    for (int i = len - 2; i >= 0; i--) begin
      @(negedge sdClk);
      cmdIn = bits[i];
    end
    @(negedge sdClk);
    cmdIn = 1'b1;
  endtask

  // driver: issue, capture frame, play the card's reply
  task automatic runCmd(input logic [15:0] word, input logic [31:0] arg,
                        input logic [135:0] reply, input int len, input int gap,
                        input expItem_t e, input logic holdBusy, input logic poke,
                        input logic chkNone);
    logic [47:0] frame, want;
    logic [39:0] h;
    expQ.push_back(e);
    if (holdBusy) dat0In = 1'b0;
    @(negedge clk);
    cmdWord = word; cmdArg = arg; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    do @(posedge sdClk); while (!cmdOe);
    frame[47] = cmdOut;
    for (int i = 46; i >= 0; i--) begin
      @(posedge sdClk);
      frame[i] = cmdOut;
    end
    h = {2'b01, word[5:0], arg};
    want = {h, benchCrc(h), 1'b1};
    chk("R1", "frame hi", frame[47:16], want[47:16]);
    chk("R1", "frame lo", {16'h0, frame[15:0]}, {16'h0, want[15:0]});
    if (chkNone) begin
      repeat (4) @(negedge clk);
      chk("R4", "respDone soon after release", {31'h0, respDone}, 32'h1);
    end
    if (poke) begin
      @(negedge clk);
      cmdWord = 16'h0403; cmdArg = 32'hFFFF0000; issueValid = 1'b1;
      @(negedge clk);
      issueValid = 1'b0; cmdWord = word; cmdArg = arg;
    end
    if (len > 0) cardReply(reply, len, gap);
    if (holdBusy) begin
      repeat (20) @(negedge clk);
      chk("R12", "busy held by DAT0", {30'h0, busy, respDone}, 32'h2);
      dat0In = 1'b1;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    if (poke) begin
      logic seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (cmdOe || busy) seen = 1'b1;
      end
      chk("R2", "no frame from ignored issue", {31'h0, seen}, 32'h0);
    end
  endtask

  // monitor: compares flags and registers when an exchange ends
  initial begin
    forever begin
      @(negedge busy);
      @(negedge clk);
      if (expQ.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2 unexpected completion: actual 1 expected 0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(e.req, "respDone", {31'h0, respDone}, {31'h0, e.done});
        chk(e.req, "errTimeout", {31'h0, errTimeout}, {31'h0, e.tmo});
        chk(e.req, "errCrc", {31'h0, errCrc}, {31'h0, e.crc});
        chk(e.req, "errEnd", {31'h0, errEnd}, {31'h0, e.endE});
        chk(e.req, "errIndex", {31'h0, errIndex}, {31'h0, e.idx});
        if (e.chkResp) begin
          chk(e.req, "resp0", resp0, e.r0);
          chk(e.req, "resp1", resp1, e.r1);
          chk(e.req, "resp2", resp2, e.r2);
          chk(e.req, "resp3", resp3, e.r3);
        end
      end
    end
  end

  task automatic finishRun;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    logic [135:0] b;
    logic [126:0] content;
    expItem_t e;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "reset flags", {26'h0, busy, respDone, errTimeout, errCrc, errEnd, errIndex}, 32'h0);
    chk("R13", "reset line", {30'h0, cmdOut, cmdOe}, 32'h2);

    // R5 short response, R1 framing
    b = mkShort(6'd17, 32'h0000_0900, 1'b0, 1'b1);
    e = mkExp("R5", 1, 0, 0, 0, 0, 1, b, 0);
    runCmd(16'h0411, 32'hA5A5_3C3C, b, 48, 2, e, 0, 0, 0);

    // R7 boundary: start bit at 64th edge accepted
    b = mkShort(6'd13, 32'h1234_5678, 1'b0, 1'b1);
    e = mkExp("R7", 1, 0, 0, 0, 0, 1, b, 0);
    runCmd(16'h040D, 32'h0001_0000, b, 48, 64, e, 0, 0, 0);

    // R7 no reply at all: timeout
    e = mkExp("R7", 0, 1, 0, 0, 0, 0, b, 0);
    runCmd(16'h0408, 32'h0000_01AA, b, 0, 1, e, 0, 0, 0);

    // R7 start bit at 65th edge: timeout
    b = mkShort(6'd8, 32'h0000_01AA, 1'b0, 1'b1);
    e = mkExp("R7", 0, 1, 0, 0, 0, 0, b, 0);
    expQ.push_back(e);
    @(negedge clk);
    cmdWord = 16'h0408; cmdArg = 32'h0000_01AA; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    do @(posedge sdClk); while (!cmdOe);
    repeat (47) @(posedge sdClk);
    cardReply(b, 48, 65);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    // R4 no response type
    e = mkExp("R4", 1, 0, 0, 0, 0, 0, b, 0);
    runCmd(16'h0307, 32'h0000_0000, b, 0, 1, e, 0, 0, 1);

    // R8 CRC error
    b = mkShort(6'd17, 32'hCAFE_0001, 1'b1, 1'b1);
    e = mkExp("R8", 1, 0, 1, 0, 0, 0, b, 0);
    runCmd(16'h0411, 32'h0000_0010, b, 48, 3, e, 0, 0, 0);

    // R9 end bit error
    b = mkShort(6'd17, 32'hCAFE_0002, 1'b0, 1'b0);
    e = mkExp("R9", 1, 0, 0, 1, 0, 0, b, 0);
    runCmd(16'h0411, 32'h0000_0020, b, 48, 2, e, 0, 0, 0);

    // R10 index error
    b = mkShort(6'd18, 32'hCAFE_0003, 1'b0, 1'b1);
    e = mkExp("R10", 1, 0, 0, 0, 1, 0, b, 0);
    runCmd(16'h0411, 32'h0000_0030, b, 48, 2, e, 0, 0, 0);

    // R6 and R11 long response with junk CRC field
    content = {31'h3C0F_1E2D, 32'hA1B2_C3D4, 32'h55AA_0FF0, 32'hDEAD_BEEF};
    b = {2'b00, 6'h3F, content, 1'b1};
    e = mkExp("R6", 1, 0, 0, 0, 0, 1, b, 1);
    runCmd(16'h0609, 32'h0001_0000, b, 136, 2, e, 0, 0, 0);

    // R11 OCR-style short response: index and CRC all ones
    b = {88'b0, 2'b00, 6'h3F, 32'h80FF_8000, 7'h7F, 1'b1};
    e = mkExp("R11", 1, 0, 0, 0, 0, 1, b, 0);
    runCmd(16'h0729, 32'h40FF_8000, b, 48, 2, e, 0, 0, 0);

    // R12 busy response held by DAT0
    b = mkShort(6'd7, 32'h0000_0700, 1'b0, 1'b1);
    e = mkExp("R12", 1, 0, 0, 0, 0, 1, b, 0);
    runCmd(16'h0507, 32'h0001_0000, b, 48, 2, e, 1, 0, 0);

    // R3 auto: index 0 -> none
    e = mkExp("R3", 1, 0, 0, 0, 0, 0, b, 0);
    runCmd(16'h0000, 32'h0000_0000, b, 0, 1, e, 0, 0, 1);

    // R3 auto: index 2 -> long
    content = {31'h0102_0304, 32'h0506_0708, 32'h090A_0B0C, 32'h0D0E_0F10};
    b = {2'b00, 6'h3F, content, 1'b1};
    e = mkExp("R3", 1, 0, 0, 0, 0, 1, b, 1);
    runCmd(16'h0002, 32'h0000_0000, b, 136, 2, e, 0, 0, 0);

    // R3 auto: app index 41 -> OCR-style, no checks
    b = {88'b0, 2'b00, 6'h3F, 32'hC0FF_8000, 7'h7F, 1'b1};
    e = mkExp("R3", 1, 0, 0, 0, 0, 1, b, 0);
    runCmd(16'h0069, 32'h40FF_8000, b, 48, 2, e, 0, 0, 0);

    // R2 issue during busy ignored
    b = mkShort(6'd16, 32'h0000_0200, 1'b0, 1'b1);
    e = mkExp("R2", 1, 0, 0, 0, 0, 1, b, 0);
    runCmd(16'h0410, 32'h0000_0200, b, 48, 10, e, 0, 1, 0);

    // R13 clearStatus clears flags
    @(negedge clk);
    clearStatus = 1'b1;
    @(negedge clk);
    clearStatus = 1'b0;
    @(negedge clk);
    chk("R13", "flags after clear", {27'h0, respDone, errTimeout, errCrc, errEnd, errIndex}, 32'h0);

    finishRun();
  end

endmodule